// File: doc/BRIEF.md
# Vertical Blank NMI Flag Controller

This block holds the vertical-blank status flag and the non-maskable interrupt request line for a CPU. A raster timer feeds it single-cycle strobes for frame wrap, vertical-blank start and line wrap. The timer also supplies the current horizontal count and the length of the current line. The CPU supplies the interrupt-enable bit and a read strobe for the status byte.

When vertical blank begins, the flag is raised. If interrupts are enabled, the request line is also raised and a trigger position is armed a fixed number of cycles into the line. The `nmi_take` output pulses when the horizontal count reaches that position. If a line ends before the trigger is reached, the trigger carries into the next line. A frame wrap clears the flag, drops the line and disarms the trigger. It also flips a field bit and clears the beam-position-latched indication.

The status byte presents the flag in its top bit and a fixed chip version in its low bits. Reading the byte clears the flag one cycle later.

Top module: `vbn_nmi_ctrl`

## Requirements
- R1: After reset, status bit 7 is 0, `nmi_line` is 0, `trig_pos` is 0xFFFF (the code meaning no trigger is armed), `field_bit` is 0 and `beam_latched` is 0.
- R2: `status_byte[3:0]` always equals the parameter VERSION (default 2), `status_byte[6:4]` are 0, and `status_byte[7]` is the vertical-blank flag.
- R3: A `vblank_start` strobe sets status bit 7 in the next cycle.
- R4: A `vblank_start` strobe with `nmi_enable` high raises `nmi_line` and loads `trig_pos` with 12 (6 plus 6) in the next cycle. With `nmi_enable` low, the strobe leaves `nmi_line` and `trig_pos` as they were, apart from the effect of any frame wrap in the same cycle.
- R5: A `frame_wrap` strobe without `vblank_start` clears status bit 7, drops `nmi_line` and sets `trig_pos` to 0xFFFF in the next cycle.
- R6: On a `line_wrap` strobe, if `trig_pos` is not 0xFFFF and `trig_pos >= line_len`, then `trig_pos` becomes `trig_pos - line_len` in the next cycle. Otherwise `trig_pos` is unchanged by the strobe.
- R7: `nmi_take` is high in the same cycle exactly when `nmi_line` is 1, `trig_pos` is not 0xFFFF and `hcount == trig_pos`. In the next cycle `trig_pos` becomes 0xFFFF unless `vblank_start` or `frame_wrap` occurred in that cycle. `nmi_line` is unaffected by the take.
- R8: During a `status_rd` cycle, `status_byte` shows the current flag. Bit 7 reads 0 in the next cycle unless `vblank_start` occurred in the same cycle, in which case the set wins.
- R9: `field_bit` inverts in the cycle after every `frame_wrap` and is otherwise held.
- R10: `beam_latched` becomes 1 after a `latch_set` strobe and 0 after a `frame_wrap` strobe. When both arrive together, the clear wins.
- R11: When `vblank_start` and `frame_wrap` arrive in the same cycle, the vertical-blank set wins for the flag. `nmi_line` and `trig_pos` then take 1 and 12 if `nmi_enable` is high, or 0 and 0xFFFF if it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wrap | input | 1 | Vertical counter wrapped to line 0 |
| vblank_start | input | 1 | First vertical-blank line reached |
| line_wrap | input | 1 | Horizontal counter wrapped |
| line_len | input | 16 | Length of the line that is ending |
| hcount | input | 16 | Current horizontal position |
| nmi_enable | input | 1 | Interrupt-enable register bit 7 |
| status_rd | input | 1 | CPU read of the status byte |
| latch_set | input | 1 | Beam position latched event |
| status_byte | output | 8 | Flag in bit 7, version in bits 3:0 |
| nmi_line | output | 1 | Interrupt request line |
| nmi_take | output | 1 | Trigger position reached this cycle |
| trig_pos | output | 16 | Armed trigger position, 0xFFFF when none |
| field_bit | output | 1 | Per-frame toggling status bit |
| beam_latched | output | 1 | Beam-position-latched indication |

## Verification
A wrong flag state appears on `status_byte[7]` one cycle after the strobe or read that should have changed it, so the CPU would misread vertical blank on its very next poll. A mis-carried or unconsumed trigger shows up on `trig_pos` one cycle after a line wrap or take. That error then turns into a missing, extra or wrongly placed `nmi_take` pulse on a later line. Random sequences mix colliding strobes with short line lengths, so carries and takes occur often. Directed cases cover each priority collision.

// File: rtl/vbn_pkg.sv
package vbn_pkg;
  localparam int unsigned POS_W = 16;
  localparam logic [POS_W-1:0] POS_NONE = '1;
endpackage

// File: rtl/vbn_status_reg.sv
module vbn_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_start,
  input  logic frame_wrap,
  input  logic status_rd,
  input  logic latch_set,
  output logic flag_q,
  output logic field_q,
  output logic latched_q
);
  logic flag_d, field_d, latched_d;
  logic flag_en, field_en, latched_en;

  always_comb begin
    flag_en    = vblank_start | frame_wrap | status_rd;
    flag_d     = vblank_start;
    field_en   = frame_wrap;
    field_d    = ~field_q;
    latched_en = frame_wrap | latch_set;
    latched_d  = ~frame_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      field_q   <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      if (flag_en)    flag_q    <= flag_d;
      if (field_en)   field_q   <= field_d;
      if (latched_en) latched_q <= latched_d;
    end
  end
endmodule

// File: rtl/vbn_trigger.sv
module vbn_trigger
  import vbn_pkg::*;
#(
  parameter logic [POS_W-1:0] TRIG_AT = 16'd12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vblank_start,
  input  logic             frame_wrap,
  input  logic             line_wrap,
  input  logic             nmi_enable,
  input  logic [POS_W-1:0] line_len,
  input  logic [POS_W-1:0] hcount,
  output logic             line_q,
  output logic [POS_W-1:0] pos_q,
  output logic             take
);
  logic             arm;
  logic             armed;
  logic             carry;
  logic             line_d, line_en;
  logic [POS_W-1:0] pos_d;
  logic             pos_en;

  always_comb begin
    arm   = vblank_start & nmi_enable;
    armed = (pos_q != POS_NONE);
    take  = line_q & armed & (hcount == pos_q);
    carry = line_wrap & armed & (pos_q >= line_len);

    line_en = arm | frame_wrap;
    line_d  = arm;

    pos_en = 1'b1;
    if (arm)             pos_d = TRIG_AT;
    else if (frame_wrap) pos_d = POS_NONE;
    else if (take)       pos_d = POS_NONE;
    else if (carry)      pos_d = pos_q - line_len;
    else begin
      pos_d  = pos_q;
      pos_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pos_q  <= POS_NONE;
    end else begin
      if (line_en) line_q <= line_d;
      if (pos_en)  pos_q  <= pos_d;
    end
  end
endmodule

// File: rtl/vbn_nmi_ctrl.sv
module vbn_nmi_ctrl
  import vbn_pkg::*;
#(
  parameter int unsigned VER_W      = 4,
  parameter logic [VER_W-1:0] VERSION = 4'd2,
  parameter int unsigned TRIG_BASE  = 6,
  parameter int unsigned TRIG_DELAY = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_wrap,
  input  logic             vblank_start,
  input  logic             line_wrap,
  input  logic [POS_W-1:0] line_len,
  input  logic [POS_W-1:0] hcount,
  input  logic             nmi_enable,
  input  logic             status_rd,
  input  logic             latch_set,
  output logic [7:0]       status_byte,
  output logic             nmi_line,
  output logic             nmi_take,
  output logic [POS_W-1:0] trig_pos,
  output logic             field_bit,
  output logic             beam_latched
);
  localparam int unsigned PAD_W = 7 - VER_W;
  localparam logic [POS_W-1:0] TRIG_AT = POS_W'(TRIG_BASE + TRIG_DELAY);

  logic flag;

  vbn_status_reg u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .vblank_start (vblank_start),
    .frame_wrap   (frame_wrap),
    .status_rd    (status_rd),
    .latch_set    (latch_set),
    .flag_q       (flag),
    .field_q      (field_bit),
    .latched_q    (beam_latched)
  );

  vbn_trigger #(.TRIG_AT(TRIG_AT)) u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .vblank_start (vblank_start),
    .frame_wrap   (frame_wrap),
    .line_wrap    (line_wrap),
    .nmi_enable   (nmi_enable),
    .line_len     (line_len),
    .hcount       (hcount),
    .line_q       (nmi_line),
    .pos_q        (trig_pos),
    .take         (nmi_take)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_byte = {flag, {PAD_W{1'b0}}, VERSION};
    end else begin : g_nopad
      assign status_byte = {flag, VERSION};
    end
  endgenerate
endmodule

// File: rtl/vbn_nmi_chk.sv
module vbn_nmi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_wrap,
  input logic        vblank_start,
  input logic        line_wrap,
  input logic [15:0] line_len,
  input logic [15:0] hcount,
  input logic        nmi_enable,
  input logic        status_rd,
  input logic        latch_set,
  input logic [7:0]  status_byte,
  input logic        nmi_line,
  input logic        nmi_take,
  input logic [15:0] trig_pos,
  input logic        field_bit,
  input logic        beam_latched
);
  a_r2_version: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:0] == 7'd2);

  a_r3_vblank_sets: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> status_byte[7]);

  a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && nmi_enable) |=> (nmi_line && trig_pos == 16'd12));

  a_r5_wrap_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && !vblank_start) |=> (!status_byte[7] && !nmi_line && trig_pos == 16'hFFFF));

  a_r6_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wrap && !vblank_start && !frame_wrap && !nmi_take &&
     trig_pos != 16'hFFFF && trig_pos >= line_len)
    |=> trig_pos == $past(trig_pos) - $past(line_len));

  a_r7_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_take && !vblank_start && !frame_wrap) |=> (trig_pos == 16'hFFFF && nmi_line));

  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !vblank_start) |=> !status_byte[7]);

  a_r9_field: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> field_bit != $past(field_bit));

  a_r10_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> !beam_latched);

  a_r11_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && frame_wrap && !nmi_enable) |=> (status_byte[7] && !nmi_line));
endmodule

bind vbn_nmi_ctrl vbn_nmi_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_wrap   (frame_wrap),
  .vblank_start (vblank_start),
  .line_wrap    (line_wrap),
  .line_len     (line_len),
  .hcount       (hcount),
  .nmi_enable   (nmi_enable),
  .status_rd    (status_rd),
  .latch_set    (latch_set),
  .status_byte  (status_byte),
  .nmi_line     (nmi_line),
  .nmi_take     (nmi_take),
  .trig_pos     (trig_pos),
  .field_bit    (field_bit),
  .beam_latched (beam_latched)
);

// File: tb/tb_vbn_nmi_ctrl.sv
module tb_vbn_nmi_ctrl;
  logic        clk, rst_n;
  logic        frame_wrap, vblank_start, line_wrap, nmi_enable, status_rd, latch_set;
  logic [15:0] line_len, hcount;
  logic [7:0]  status_byte;
  logic        nmi_line, nmi_take, field_bit, beam_latched;
  logic [15:0] trig_pos;

  int checks = 0;
  int failures = 0;

  logic        m_flag, m_line, m_field, m_lat;
  logic [15:0] m_trig;

  vbn_nmi_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frame_wrap(frame_wrap), .vblank_start(vblank_start),
    .line_wrap(line_wrap), .line_len(line_len), .hcount(hcount), .nmi_enable(nmi_enable),
    .status_rd(status_rd), .latch_set(latch_set), .status_byte(status_byte),
    .nmi_line(nmi_line), .nmi_take(nmi_take), .trig_pos(trig_pos),
    .field_bit(field_bit), .beam_latched(beam_latched)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_take();
    return m_line && (m_trig != 16'hFFFF) && (hcount == m_trig);
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_flag, 7'd2};
  endfunction

  task automatic model_step();
    logic tk;
    tk = exp_take();
    if (vblank_start && nmi_enable) m_trig = 16'd12;
    else if (frame_wrap) m_trig = 16'hFFFF;
    else if (tk) m_trig = 16'hFFFF;
    else if (line_wrap && m_trig != 16'hFFFF && m_trig >= line_len) m_trig = m_trig - line_len;
    if (vblank_start && nmi_enable) m_line = 1'b1;
    else if (frame_wrap) m_line = 1'b0;
    if (vblank_start) m_flag = 1'b1;
    else if (frame_wrap || status_rd) m_flag = 1'b0;
    if (frame_wrap) m_field = ~m_field;
    if (frame_wrap) m_lat = 1'b0;
    else if (latch_set) m_lat = 1'b1;
  endtask

  task automatic idle();
    frame_wrap = 0; vblank_start = 0; line_wrap = 0; status_rd = 0; latch_set = 0;
  endtask

  // Inputs already driven at negedge; check combinational outputs, advance, check registers.
  task automatic step();
    #1;
    chk("R7 take", 16'(nmi_take), 16'(exp_take()));
    chk("R2/R8 status", 16'(status_byte), 16'(exp_status()));
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R3/R5/R8 flag", 16'(status_byte[7]), 16'(m_flag));
    chk("R4/R5/R11 line", 16'(nmi_line), 16'(m_line));
    chk("R4/R6/R7 trig", trig_pos, m_trig);
    chk("R9 field", 16'(field_bit), 16'(m_field));
    chk("R10 latched", 16'(beam_latched), 16'(m_lat));
    idle();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; idle(); nmi_enable = 0; line_len = 16'd20; hcount = 16'd0;
    m_flag = 0; m_line = 0; m_field = 0; m_lat = 0; m_trig = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 flag", 16'(status_byte[7]), 16'd0);
    chk("R1 line", 16'(nmi_line), 16'd0);
    chk("R1 trig", trig_pos, 16'hFFFF);
    chk("R1 field", 16'(field_bit), 16'd0);
    chk("R1 latched", 16'(beam_latched), 16'd0);
    chk("R2 version", 16'(status_byte), 16'h02);
    rst_n = 1;
    @(negedge clk);

    // R4: vblank without enable leaves line low
    vblank_start = 1; nmi_enable = 0; hcount = 16'd100; step();
    chk("R4 no enable", 16'(nmi_line), 16'd0);
    // R8 vs R3 collision: set wins
    vblank_start = 1; status_rd = 1; step();
    chk("R8 set wins", 16'(status_byte[7]), 16'd1);
    // R8: plain read clears next cycle
    status_rd = 1; step();
    chk("R8 read clears", 16'(status_byte[7]), 16'd0);
    // R4 arm
    vblank_start = 1; nmi_enable = 1; step();
    chk("R4 trig 12", trig_pos, 16'd12);
    // R6 carry: line length 5 -> 7
    line_wrap = 1; line_len = 16'd5; step();
    chk("R6 carry", trig_pos, 16'd7);
    // R6 no carry when trig < len
    line_wrap = 1; line_len = 16'd8; step();
    chk("R6 hold", trig_pos, 16'd7);
    // R7 take at hcount 7
    hcount = 16'd7; step();
    chk("R7 consumed", trig_pos, 16'hFFFF);
    chk("R7 line kept", 16'(nmi_line), 16'd1);
    // R10 latch then wrap+latch
    latch_set = 1; step();
    chk("R10 set", 16'(beam_latched), 16'd1);
    frame_wrap = 1; latch_set = 1; step();
    chk("R10 clear wins", 16'(beam_latched), 16'd0);
    chk("R5 line down", 16'(nmi_line), 16'd0);
    // R11 collision with enable
    vblank_start = 1; frame_wrap = 1; nmi_enable = 1; step();
    chk("R11 armed", trig_pos, 16'd12);
    chk("R11 flag", 16'(status_byte[7]), 16'd1);

    for (int i = 0; i < 3000; i++) begin
      frame_wrap   = ($urandom_range(0, 15) == 0);
      vblank_start = ($urandom_range(0, 11) == 0);
      line_wrap    = ($urandom_range(0, 3) == 0);
      status_rd    = ($urandom_range(0, 5) == 0);
      latch_set    = ($urandom_range(0, 7) == 0);
      nmi_enable   = ($urandom_range(0, 3) != 0);
      line_len     = 16'($urandom_range(3, 18));
      hcount       = 16'($urandom_range(0, 14));
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule